// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an asynchronous static RAM of 524,288 bytes. The host offers one access at a time with a level request, a read/write flag, a 19-bit address and a byte of write data. It holds that request until a single-cycle acknowledge comes back. The controller turns each request into a correctly timed strobe sequence on the memory pins. These are an active-low select, an active-low write strobe and an active-low output enable, with a data bus split into an outgoing byte, an incoming byte and a drive-enable for the pad.

Every strobe width and gap is a whole number of clocks. Each one comes from a nanosecond parameter and the clock period as the ceiling of their quotient, and any nonzero interval takes at least one clock. The controller keeps output enable high for the whole of a write. It does not switch its own data drivers on until the memory's outputs have had the float time to go high-impedance since output enable was last low. As a result, the two sides never drive the bus at once.

For the memory, select high is standby. Select low with output enable low and write strobe high is a read. Select low with the write strobe low is a write, and the write lasts exactly as long as both are low.

Top module: `asram_bridge`

## Requirements
- R1: While reset is low, and immediately when it is asserted in the middle of an access, select, write strobe and output enable are all high, the data drive-enable is off and acknowledge is low.
- R2: A read holds select and output enable low with the write strobe high for RD_CYC clocks, where RD_CYC is the largest of the cycle counts for read cycle time, address access, select access and output-enable access. Read data is the incoming bus byte sampled at the end of those clocks, and acknowledge is high in the clock right after the strobes rise.
- R3: A write holds select and write strobe low with output enable high for WR_CYC clocks, where WR_CYC is the largest of the counts for write pulse, select-to-end, address-to-end and data setup. The drive-enable is on and the host's write byte is on the outgoing bus for the whole of that time.
- R4: After a write pulse, the strobes stay high with data still driven for REC_CYC = max(1, write-cycle count minus WR_CYC) clocks, and then acknowledge is raised.
- R5: The drive-enable turns on no sooner than TURN_CYC = max(1, float-time count) clock edges after output enable last rose. A write presented in the acknowledge clock of a read therefore waits TURN_CYC-1 extra clocks with all strobes high. A write after a write or after idle time does not wait.
- R6: The drive-enable is never on while output enable is low.
- R7: Acknowledge lasts exactly one clock, and select is high during it.
- R8: With no request pending, all strobes stay high and the drive-enable stays off.
- R9: Each cycle count is the nanosecond value divided by the clock period, rounded up, with a minimum of one for a nonzero value. The defaults are 10 ns clock, 55 ns read and write cycle, 40 ns write pulse, 45 ns select and address to end of write, 25 ns data setup and 20 ns float. These give RD_CYC 6, WR_CYC 5, REC_CYC 1 and TURN_CYC 2.
- R10: While select is low, the memory address equals the address the host presented with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 8 | Byte captured by the last read |
| ram_a | output | 19 | Memory address |
| ram_sel_n | output | 1 | Memory select, active low |
| ram_wstb_n | output | 1 | Memory write strobe, active low |
| ram_oen_n | output | 1 | Memory output enable, active low |
| ram_dout | output | 8 | Byte driven toward the memory |
| ram_din | input | 8 | Byte received from the memory |
| ram_drive | output | 1 | Enables the controller's bus drivers |

## Verification
The hardest case to reach is a write that follows a read as closely as the handshake allows. Only then does the float-time wait show up as extra clocks with all strobes high. The stimulus table places writes right after reads, and each new request is presented in the same clock that the previous acknowledge is seen. Writes after writes and after reset provide the contrasting case with no wait. A reset asserted while the write strobe is low covers the abort path.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WGAP,
    ST_WRITE,
    ST_WREC
  } ctl_state_e;

  typedef struct packed {
    logic sel_n;
    logic wstb_n;
    logic oen_n;
    logic drive;
  } strobe_t;

  // Clocks covering an interval: rounded up, at least one when nonzero.
  function automatic int ns_to_cyc(input int ns, input int per);
    if (ns <= 0) return 0;
    return (ns + per - 1) / per;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels that each state presents to the memory.
  function automatic strobe_t decode(input ctl_state_e s);
    strobe_t o;
    o = '{sel_n: 1'b1, wstb_n: 1'b1, oen_n: 1'b1, drive: 1'b0};
    case (s)
      ST_READ:  begin o.sel_n = 1'b0; o.oen_n = 1'b0; end
      ST_WRITE: begin o.sel_n = 1'b0; o.wstb_n = 1'b0; o.drive = 1'b1; end
      ST_WREC:  o.drive = 1'b1;
      default:  ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_CA_NS  = 55,
  parameter int T_OE_NS  = 25,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 40,
  parameter int T_CW_NS  = 45,
  parameter int T_AW_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_HZ_NS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_wr,
  output logic accept,
  output logic capture,
  output logic ack,
  output logic sel_n,
  output logic wstb_n,
  output logic oen_n,
  output logic drive
);

  localparam int RD_CYC = max_of(1, max_of(max_of(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                           max_of(ns_to_cyc(T_CA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS))));
  localparam int WR_CYC = max_of(1, max_of(max_of(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                                           max_of(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS))));
  localparam int REC_CYC  = max_of(1, ns_to_cyc(T_WC_NS, CLK_NS) - WR_CYC);
  localparam int TURN_CYC = max_of(1, ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int MAX_CYC  = max_of(max_of(RD_CYC, WR_CYC), REC_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int QW       = $clog2(TURN_CYC + 1);

  ctl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [QW-1:0]    quiet_q;
  strobe_t          pins_q;
  logic             ack_q;
  logic             finish;
  logic             cyc_done;
  logic             turn_ok;

  assign cyc_done = (cnt_q == '0);
  // Drivers switching on at the coming edge would respect the float time.
  assign turn_ok  = (quiet_q >= QW'(TURN_CYC - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cyc_done ? cnt_q : cnt_q - 1'b1;
    accept  = 1'b0;
    capture = 1'b0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          if (!req_wr) begin
            state_d = ST_READ;
            cnt_d   = CNT_W'(RD_CYC - 1);
          end else if (turn_ok) begin
            state_d = ST_WRITE;
            cnt_d   = CNT_W'(WR_CYC - 1);
          end else begin
            state_d = ST_WGAP;
          end
        end
      end
      ST_READ: begin
        if (cyc_done) begin
          capture = 1'b1;
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WGAP: begin
        if (turn_ok) begin
          state_d = ST_WRITE;
          cnt_d   = CNT_W'(WR_CYC - 1);
        end
      end
      ST_WRITE: begin
        if (cyc_done) begin
          state_d = ST_WREC;
          cnt_d   = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WREC: begin
        if (cyc_done) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pins_q  <= decode(ST_IDLE);
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pins_q  <= decode(state_d);
      ack_q   <= finish;
    end
  end

  // Clocks elapsed since output enable was last low, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    quiet_q <= QW'(TURN_CYC);
    else if (!pins_q.oen_n)        quiet_q <= '0;
    else if (quiet_q != QW'(TURN_CYC)) quiet_q <= quiet_q + 1'b1;
  end

  assign sel_n  = pins_q.sel_n;
  assign wstb_n = pins_q.wstb_n;
  assign oen_n  = pins_q.oen_n;
  assign drive  = pins_q.drive;
  assign ack    = ack_q;

  // Length of the current write-strobe low period, for the checks below.
  logic [CNT_W-1:0] wlow_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wlow_q <= '0;
    else if (!wstb_n) wlow_q <= wlow_q + 1'b1;
    else              wlow_q <= '0;
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> oen_n); // R6
  AST_DRIVE_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> (quiet_q >= QW'(TURN_CYC))); // R5
  AST_WRITE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wstb_n) |-> (wlow_q >= CNT_W'(WR_CYC))); // R3
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb_n |-> (oen_n && !sel_n && drive)); // R3
  AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!sel_n && !oen_n && wstb_n)); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R7
  AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> sel_n); // R7

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] a_out,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out <= '0;
      dout  <= '0;
    end else if (load) begin
      a_out <= addr_in;
      dout  <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= din;
  end

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_CA_NS = 55,
  parameter int T_OE_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_CW_NS = 45,
  parameter int T_AW_NS = 45,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] ram_a,
  output logic              ram_sel_n,
  output logic              ram_wstb_n,
  output logic              ram_oen_n,
  output logic [DATA_W-1:0] ram_dout,
  input  logic [DATA_W-1:0] ram_din,
  output logic              ram_drive
);

  logic accept_evt;
  logic capture_evt;

  asram_seq #(
    .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_CA_NS(T_CA_NS),
    .T_OE_NS(T_OE_NS), .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS), .T_CW_NS(T_CW_NS),
    .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS), .T_HZ_NS(T_HZ_NS)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (host_req),
    .req_wr  (host_wr),
    .accept  (accept_evt),
    .capture (capture_evt),
    .ack     (host_ack),
    .sel_n   (ram_sel_n),
    .wstb_n  (ram_wstb_n),
    .oen_n   (ram_oen_n),
    .drive   (ram_drive)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .capture  (capture_evt),
    .addr_in  (host_addr),
    .wdata_in (host_wdata),
    .din      (ram_din),
    .a_out    (ram_a),
    .dout     (ram_dout),
    .rdata    (host_rdata)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n && $past(!ram_sel_n)) |-> $stable(ram_a)); // R10
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_drive && $past(ram_drive)) |-> $stable(ram_dout)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel_n && !ram_drive) |-> (ram_wstb_n && ram_oen_n)); // R8

endmodule

// File: tb/test_asram_bridge.sv
module test_asram_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // Bench-side rounding: smallest n with n*period >= ns.
  function automatic int clocks_for(input int ns);
    int n;
    n = 0;
    while (n * CLK_PERIOD < ns) n++;
    return n;
  endfunction
  function automatic int bigger(input int a, input int b);
    if (a >= b) return a;
    return b;
  endfunction

  localparam int E_RD   = bigger(bigger(clocks_for(55), clocks_for(55)), bigger(clocks_for(55), clocks_for(25)));
  localparam int E_WR   = bigger(bigger(clocks_for(40), clocks_for(45)), bigger(clocks_for(45), clocks_for(25)));
  localparam int E_REC  = bigger(1, clocks_for(55) - E_WR);
  localparam int E_TURN = bigger(1, clocks_for(20));

  // {write flag, address, data}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 19'h00000, 8'h5A},
    {1'b1, 19'h7FFFF, 8'hC3},
    {1'b0, 19'h00000, 8'h00},
    {1'b1, 19'h12345, 8'h00},
    {1'b0, 19'h7FFFF, 8'h00},
    {1'b0, 19'h12345, 8'h00},
    {1'b1, 19'h40001, 8'hFF},
    {1'b0, 19'h40001, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [18:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic [18:0] ram_a;
  logic        ram_sel_n, ram_wstb_n, ram_oen_n, ram_drive;
  logic [7:0]  ram_dout, ram_din;

  int checks = 0;
  int errors = 0;
  logic prev_rd = 1'b0;
  logic [7:0] model [64];
  logic [7:0] shadow [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  asram_bridge i_asram_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .ram_a(ram_a), .ram_sel_n(ram_sel_n),
    .ram_wstb_n(ram_wstb_n), .ram_oen_n(ram_oen_n), .ram_dout(ram_dout),
    .ram_din(ram_din), .ram_drive(ram_drive)
  );

  // Memory model: stores while select and write strobe are low, answers reads.
  initial for (int i = 0; i < 64; i++) model[i] = 8'hA5;
  always @(posedge clk)
    if (!ram_sel_n && !ram_wstb_n && ram_drive) model[ram_a[5:0]] = ram_dout;
  assign ram_din = (!ram_sel_n && !ram_oen_n && ram_wstb_n) ? model[ram_a[5:0]] : 8'hEE;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [18:0] ad, input logic [7:0] wd);
    int lat, n_sel, n_oe, n_we, n_hold, n_fight, n_bad, n_amove, exp_lat;
    lat = 0; n_sel = 0; n_oe = 0; n_we = 0; n_hold = 0; n_fight = 0; n_bad = 0; n_amove = 0;
    host_req = 1'b1; host_wr = wr; host_addr = ad; host_wdata = wd;
    do begin
      @(negedge clk);
      lat++;
      if (!ram_sel_n) n_sel++;
      if (!ram_oen_n) n_oe++;
      if (!ram_wstb_n) n_we++;
      if (ram_drive && ram_sel_n) n_hold++;
      if (ram_drive && !ram_oen_n) n_fight++;
      if (!ram_wstb_n && ram_dout !== wd) n_bad++;
      if (!ram_sel_n && ram_a !== ad) n_amove++;
    end while (!host_ack && lat < 100);
    host_req = 1'b0;
    chk("R7 ack seen", int'(host_ack), 1);
    chk("R7 select high at ack", int'(ram_sel_n), 1);
    chk("R6 drive with oe low", n_fight, 0);
    chk("R10 address held", n_amove, 0);
    if (wr) begin
      exp_lat = (prev_rd ? E_TURN - 1 : 0) + E_WR + E_REC + 1;
      chk(prev_rd ? "R5 R9 write latency after read" : "R9 write latency", lat, exp_lat);
      chk("R3 select low clocks", n_sel, E_WR);
      chk("R3 write strobe low clocks", n_we, E_WR);
      chk("R3 oe stays high", n_oe, 0);
      chk("R3 data on bus", n_bad, 0);
      chk("R4 recovery drive clocks", n_hold, E_REC);
      shadow[ad[5:0]] = wd;
    end else begin
      chk("R2 R9 read latency", lat, E_RD + 1);
      chk("R2 select low clocks", n_sel, E_RD);
      chk("R2 oe low clocks", n_oe, E_RD);
      chk("R2 no write strobe", n_we, 0);
      chk("R2 read data", int'(host_rdata), int'(shadow[ad[5:0]]));
    end
    prev_rd = !wr;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'hA5;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1 sel in reset", int'(ram_sel_n), 1);
    chk("R1 wstb in reset", int'(ram_wstb_n), 1);
    chk("R1 oe in reset", int'(ram_oen_n), 1);
    chk("R1 drive in reset", int'(ram_drive), 0);
    chk("R1 ack in reset", int'(host_ack), 0);
    rst_n = 1'b1;
    // R8 idle: nothing moves without a request
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 idle strobes", int'({ram_sel_n, ram_wstb_n, ram_oen_n, ram_drive}), 4'b1110);
    end
    for (int v = 0; v < NVEC; v++) access(VEC[v][27], VEC[v][26:8], VEC[v][7:0]);
    @(negedge clk);
    chk("R7 ack one clock", int'(host_ack), 0);
    chk("R8 idle after access", int'({ram_sel_n, ram_wstb_n, ram_oen_n, ram_drive}), 4'b1110);
    // R1 reset while the write strobe is low
    host_req = 1'b1; host_wr = 1'b1; host_addr = 19'h00007; host_wdata = 8'h3C;
    repeat (2) @(negedge clk);
    chk("R1 write under way", int'(ram_wstb_n), 0);
    rst_n = 1'b0;
    #1;
    chk("R1 abort sel", int'(ram_sel_n), 1);
    chk("R1 abort wstb", int'(ram_wstb_n), 1);
    chk("R1 abort drive", int'(ram_drive), 0);
    host_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    prev_rd = 1'b0;
    @(negedge clk);
    access(1'b0, 19'h00000, 8'h00);
    access(1'b1, 19'h00002, 8'h81);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule